// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Controller

This block is the digital front end of a two-channel voltage-output converter. A host writes 24-bit frames over a three-wire serial link: a frame-select strobe that is active low, a shift clock and a data line. The block samples all three with its own system clock. A completed frame is split into a command, a channel address and a 16-bit data field. The command then writes per-channel input codes, moves them into the active DAC codes, or changes configuration. The configuration covers the gain selects, the power-down modes, the internal-reference enable and the mask of channels that follow the update pin.

Each channel is double-buffered. A new code first lands in the channel's input register. It reaches the converter only when one of three things happens: a software update command, a falling edge on the update pin for channels enabled in the mask, or the end of a plain input write while the update pin is held low (synchronous mode). A clear pin and two software reset flavours return codes, or all state, to their reset values. The reference enable is gated so that the reference can never be on while both channels are powered down.

Top module: `dac2_cmd_ctrl`

## Requirements
- R1: After synchronous reset both codes are zero, both gain selects are 0, both power-down modes are 00 (normal), the update mask is 00 and the reference output is off.
- R2: A frame is 24 bits taken MSB first, one bit per falling shift-clock edge while frame-select is low. Bits 23:22 are ignored. If frame-select rises before the 24th bit, the frame is dropped and changes nothing. Bits after the 24th are ignored until frame-select rises.
- R3: Command 000 (bits 21:19) writes the data field into the input register of the addressed channels. While the update pin is high, the DAC codes stay unchanged.
- R4: Command 001 copies input to DAC for the addressed channels. Command 011 writes the input and copies it for the addressed channels. Command 010 writes the addressed inputs and then copies input to DAC on both channels.
- R5: The address (bits 18:16) decodes as 000 for channel A, 001 for channel B and 111 for both. Any other address touches no channel.
- R6: With resolution parameter RES below 16, a channel code is the top RES bits of the data field, and the low bits are ignored.
- R7: Command 110 loads the update mask from data bits 1:0 (bit 0 channel A, bit 1 channel B). A falling edge on the update pin copies input to DAC for the masked channels only.
- R8: When a command-000 frame completes while the update pin is low, the masked channels copy input to DAC in the same cycle as the other registers update.
- R9: Command 100 sets the power-down mode of every channel whose select bit is 1 in data bits 1:0 (bit 0 channel A, bit 1 channel B). The mode comes from data bits 5:4, where 00 is normal and any other value is a powered-down mode.
- R10: Command 111 with address 000 sets the reference enable from data bit 0. The reference output is on only when the enable is set and at least one channel is in mode 00.
- R11: Command 111 with address 001 loads the gain selects from data bits 1:0 (bit 0 channel A, bit 1 channel B; 1 means gain of two).
- R12: Command 101 with data bit 0 clear zeroes both input and DAC codes only. With data bit 0 set, it also returns mask, gains, power-down modes and reference enable to their reset values.
- R13: While the clear pin is low, both input and DAC codes are held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial link and the pins |
| rst | input | 1 | Synchronous active-high power-on reset |
| fsel_n | input | 1 | Frame select, low while a frame is shifted |
| sclk | input | 1 | Serial shift clock, bit taken on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| upd_n | input | 1 | Update pin: falling edge or low level triggers masked updates |
| clr_n | input | 1 | Clear pin, low holds all codes at zero |
| code_a | output | RES | Active DAC code of channel A |
| code_b | output | RES | Active DAC code of channel B |
| gain_x2 | output | 2 | Gain-of-two select, bit 0 channel A, bit 1 channel B |
| pd_mode_a | output | 2 | Power-down mode of channel A |
| pd_mode_b | output | 2 | Power-down mode of channel B |
| ref_on | output | 1 | Internal reference enable after the power-down interlock |

## Verification
A bit counter that slips moves every field boundary. The first complete frame then lands with the wrong command or address, and the fault shows at the outputs in the cycle that takes the 24th bit. Input registers cannot be seen directly, so a corrupted input code or update mask stays hidden until the next update command, pin edge or synchronous write exposes it. The bench therefore always follows pending writes with such a trigger. A reference model runs beside the design and is compared on every clock, so any divergence at the ports is flagged within one cycle of its appearance.

// File: rtl/dac2_pkg.sv
package dac2_pkg;

    localparam int FRAME_BITS = 24;
    localparam int DATA_BITS  = 16;
    localparam int NUM_CH     = 2;

    typedef enum logic [2:0] {
        CMD_WR_IN      = 3'b000,
        CMD_UPD        = 3'b001,
        CMD_WR_UPD_ALL = 3'b010,
        CMD_WR_UPD     = 3'b011,
        CMD_PWR        = 3'b100,
        CMD_SRST       = 3'b101,
        CMD_MASK       = 3'b110,
        CMD_CFG        = 3'b111
    } cmd_e;

    typedef struct packed {
        logic [1:0]           spare;
        cmd_e                 cmd;
        logic [2:0]           addr;
        logic [DATA_BITS-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [NUM_CH-1:0] wr_in;
        logic [NUM_CH-1:0] load;
        logic              code_clr;
    } chan_ctl_t;

    function automatic logic [NUM_CH-1:0] addr_to_sel(input logic [2:0] a);
        case (a)
            3'b000:  return 2'b01;
            3'b001:  return 2'b10;
            3'b111:  return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/dac2_serial_rx.sv
module dac2_serial_rx import dac2_pkg::*; (
    input  logic   clk,
    input  logic   rst,
    input  logic   fsel_n,
    input  logic   sclk,
    input  logic   sdin,
    output frame_t frame,
    output logic   frame_vld
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-2:0] shift_q;
    logic                  sclk_q;
    logic                  sclk_fall;
    logic                  take_bit;

    assign sclk_fall = sclk_q & ~sclk;
    assign take_bit  = sclk_fall & ~fsel_n & (bit_cnt < CNT_W'(FRAME_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b1;
            bit_cnt <= '0;
            shift_q <= '0;
        end else begin
            sclk_q <= sclk;
            if (fsel_n) begin
                bit_cnt <= '0;
            end else if (take_bit) begin
                bit_cnt <= bit_cnt + 1'b1;
                shift_q <= {shift_q[FRAME_BITS-3:0], sdin};
            end
        end
    end

    assign frame_vld = take_bit & (bit_cnt == CNT_W'(FRAME_BITS - 1));
    assign frame     = frame_t'({shift_q, sdin});

    // R2
    frame_abort_chk: assert property (@(posedge clk) disable iff (rst)
        fsel_n |=> (bit_cnt == '0))
        else $error("bit count survived a frame-select release");

endmodule

// File: rtl/dac2_ctrl.sv
module dac2_ctrl import dac2_pkg::*; (
    input  logic                   clk,
    input  logic                   rst,
    input  frame_t                 frame,
    input  logic                   frame_vld,
    input  logic                   upd_n,
    input  logic                   clr_n,
    output chan_ctl_t              ctl,
    output logic [NUM_CH-1:0]      gain_x2,
    output logic [NUM_CH-1:0][1:0] pd_mode,
    output logic                   ref_on
);
    logic                   upd_q;
    logic                   upd_fall;
    logic [NUM_CH-1:0]      mask_q;
    logic [NUM_CH-1:0]      gain_q;
    logic [NUM_CH-1:0][1:0] pd_q;
    logic                   ref_q;
    logic [NUM_CH-1:0]      sel;
    logic [NUM_CH-1:0]      pd_down;
    logic                   full_rst;
    logic                   unused_ok;

    assign upd_fall  = upd_q & ~upd_n;
    assign sel       = addr_to_sel(frame.addr);
    assign full_rst  = frame_vld && (frame.cmd == CMD_SRST) && frame.data[0];
    assign unused_ok = ^{frame.spare, frame.data[DATA_BITS-1:6], frame.data[3:2]};

    always_comb begin
        ctl.wr_in = '0;
        ctl.load  = '0;
        if (frame_vld) begin
            case (frame.cmd)
                CMD_WR_IN: begin
                    ctl.wr_in = sel;
                    if (!upd_n) ctl.load = mask_q;
                end
                CMD_UPD:        ctl.load = sel;
                CMD_WR_UPD_ALL: begin
                    ctl.wr_in = sel;
                    ctl.load  = '1;
                end
                CMD_WR_UPD: begin
                    ctl.wr_in = sel;
                    ctl.load  = sel;
                end
                default: ;
            endcase
        end
        if (upd_fall) ctl.load = ctl.load | mask_q;
        ctl.code_clr = ~clr_n | (frame_vld && (frame.cmd == CMD_SRST));
    end

    always_ff @(posedge clk) begin
        if (rst) upd_q <= 1'b1;
        else     upd_q <= upd_n;
    end

    always_ff @(posedge clk) begin
        if (rst || full_rst) begin
            mask_q <= '0;
            gain_q <= '0;
            pd_q   <= '0;
            ref_q  <= 1'b0;
        end else if (frame_vld) begin
            case (frame.cmd)
                CMD_PWR: begin
                    for (int c = 0; c < NUM_CH; c++)
                        if (frame.data[c]) pd_q[c] <= frame.data[5:4];
                end
                CMD_MASK: mask_q <= frame.data[NUM_CH-1:0];
                CMD_CFG: begin
                    if (frame.addr == 3'b000)      ref_q  <= frame.data[0];
                    else if (frame.addr == 3'b001) gain_q <= frame.data[NUM_CH-1:0];
                end
                default: ;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pd
        assign pd_down[c] = |pd_q[c];
    end

    assign gain_x2 = gain_q;
    assign pd_mode = pd_q;
    assign ref_on  = ref_q & ~(&pd_down);

    // R10
    ref_interlock_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && frame.cmd == CMD_PWR && frame.data[5:4] != 2'b00 && frame.data[1:0] == 2'b11)
        |=> !ref_on)
        else $error("reference left on with both channels down");

    // R12
    full_reset_chk: assert property (@(posedge clk) disable iff (rst)
        full_rst |=> (!ref_on && gain_x2 == '0 && pd_mode == '0))
        else $error("full software reset left configuration set");

endmodule

// File: rtl/dac2_chan.sv
module dac2_chan #(
    parameter int RES = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  logic           load,
    input  logic           clr,
    input  logic [RES-1:0] data,
    output logic [RES-1:0] code
);
    logic [RES-1:0] in_q;
    logic [RES-1:0] in_nxt;
    logic [RES-1:0] dac_q;

    assign in_nxt = wr ? data : in_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            in_q  <= '0;
            dac_q <= '0;
        end else begin
            in_q <= in_nxt;
            if (load) dac_q <= in_nxt;
        end
    end

    assign code = dac_q;

    // R3
    buffered_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !load && !clr) |=> $stable(dac_q))
        else $error("input write reached the active code");

endmodule

// File: rtl/dac2_cmd_ctrl.sv
module dac2_cmd_ctrl import dac2_pkg::*; #(
    parameter int RES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fsel_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              upd_n,
    input  logic              clr_n,
    output logic [RES-1:0]    code_a,
    output logic [RES-1:0]    code_b,
    output logic [NUM_CH-1:0] gain_x2,
    output logic [1:0]        pd_mode_a,
    output logic [1:0]        pd_mode_b,
    output logic              ref_on
);
    frame_t                   frame;
    logic                     frame_vld;
    chan_ctl_t                ctl;
    logic [NUM_CH-1:0][1:0]   pd_mode;
    logic [NUM_CH-1:0][RES-1:0] code_arr;

    dac2_serial_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .fsel_n    (fsel_n),
        .sclk      (sclk),
        .sdin      (sdin),
        .frame     (frame),
        .frame_vld (frame_vld)
    );

    dac2_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .frame     (frame),
        .frame_vld (frame_vld),
        .upd_n     (upd_n),
        .clr_n     (clr_n),
        .ctl       (ctl),
        .gain_x2   (gain_x2),
        .pd_mode   (pd_mode),
        .ref_on    (ref_on)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dac2_chan #(.RES(RES)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .wr   (ctl.wr_in[c]),
            .load (ctl.load[c]),
            .clr  (ctl.code_clr),
            .data (frame.data[DATA_BITS-1 -: RES]),
            .code (code_arr[c])
        );
    end

    assign code_a    = code_arr[0];
    assign code_b    = code_arr[1];
    assign pd_mode_a = pd_mode[0];
    assign pd_mode_b = pd_mode[1];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (code_a == '0 && code_b == '0 && gain_x2 == '0 &&
                 pd_mode_a == 2'b00 && pd_mode_b == 2'b00 && !ref_on))
        else $error("outputs not at reset values");

    // R13
    clear_pin_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (code_a == '0 && code_b == '0))
        else $error("codes not cleared by clear pin");

endmodule

// File: tb/dac2_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module dac2_cmd_ctrl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsel_n = 1'b1, sclk = 1'b1, sdin = 1'b0, upd_n = 1'b1, clr_n = 1'b1;
    logic [15:0] code_a, code_b;
    logic [11:0] c12_a, c12_b;
    logic [1:0]  gain_x2, pd_a, pd_b, g12, pa12, pb12;
    logic        ref_on, ref12;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    cmp_en  = 1'b0;
    string phase   = "R1";

    always #2.5 clk = ~clk;

    dac2_cmd_ctrl u_dut (
        .clk(clk), .rst(rst), .fsel_n(fsel_n), .sclk(sclk), .sdin(sdin),
        .upd_n(upd_n), .clr_n(clr_n), .code_a(code_a), .code_b(code_b),
        .gain_x2(gain_x2), .pd_mode_a(pd_a), .pd_mode_b(pd_b), .ref_on(ref_on)
    );

    dac2_cmd_ctrl #(.RES(12)) u_dut12 (
        .clk(clk), .rst(rst), .fsel_n(fsel_n), .sclk(sclk), .sdin(sdin),
        .upd_n(upd_n), .clr_n(clr_n), .code_a(c12_a), .code_b(c12_b),
        .gain_x2(g12), .pd_mode_a(pa12), .pd_mode_b(pb12), .ref_on(ref12)
    );

    // behavioural reference model
    logic [15:0] m_in [2];
    logic [15:0] m_dac[2];
    logic [1:0]  m_pd [2];
    logic [1:0]  m_mask, m_gain;
    logic        m_ref, m_sclk_q, m_upd_q;
    logic [23:0] m_sr;
    int          m_cnt;

    task automatic m_clear_codes();
        for (int c = 0; c < 2; c++) begin m_in[c] = '0; m_dac[c] = '0; end
    endtask

    task automatic m_full_reset();
        m_clear_codes();
        for (int c = 0; c < 2; c++) m_pd[c] = 2'b00;
        m_mask = 2'b00; m_gain = 2'b00; m_ref = 1'b0;
    endtask

    task automatic m_exec(logic [23:0] w);
        logic [2:0]  cmd;
        logic [2:0]  adr;
        logic [15:0] d;
        logic [1:0]  s;
        cmd = w[21:19]; adr = w[18:16]; d = w[15:0];
        s = (adr == 3'd0) ? 2'b01 : (adr == 3'd1) ? 2'b10 : (adr == 3'd7) ? 2'b11 : 2'b00;
        for (int c = 0; c < 2; c++) begin
            if (cmd inside {3'd0, 3'd2, 3'd3} && s[c]) m_in[c] = d;
        end
        for (int c = 0; c < 2; c++) begin
            case (cmd)
                3'd0: if (!upd_n && m_mask[c]) m_dac[c] = m_in[c];
                3'd1, 3'd3: if (s[c]) m_dac[c] = m_in[c];
                3'd2: m_dac[c] = m_in[c];
                3'd4: if (d[c]) m_pd[c] = d[5:4];
                default: ;
            endcase
        end
        if (cmd == 3'd5) begin
            if (d[0]) m_full_reset(); else m_clear_codes();
        end
        if (cmd == 3'd6) m_mask = d[1:0];
        if (cmd == 3'd7 && adr == 3'd0) m_ref = d[0];
        if (cmd == 3'd7 && adr == 3'd1) m_gain = d[1:0];
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_full_reset();
            m_sclk_q = 1'b1; m_upd_q = 1'b1; m_cnt = 0;
        end else begin
            if (fsel_n) m_cnt = 0;
            else if (m_sclk_q && !sclk && m_cnt < 24) begin
                m_sr = {m_sr[22:0], sdin};
                m_cnt++;
                if (m_cnt == 24) m_exec(m_sr);
            end
            if (m_upd_q && !upd_n)
                for (int c = 0; c < 2; c++) if (m_mask[c]) m_dac[c] = m_in[c];
            if (!clr_n) m_clear_codes();
            m_sclk_q = sclk; m_upd_q = upd_n;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            logic exp_ref;
            exp_ref = m_ref && !(m_pd[0] != 2'b00 && m_pd[1] != 2'b00);
            n_tests++;
            if (code_a !== m_dac[0] || code_b !== m_dac[1] ||
                c12_a !== m_dac[0][15:4] || c12_b !== m_dac[1][15:4] ||
                gain_x2 !== m_gain || pd_a !== m_pd[0] || pd_b !== m_pd[1] ||
                ref_on !== exp_ref || ref12 !== exp_ref) begin
                n_fail++;
                $display("FAIL %s model t=%0t actual=%h %h %h %h %b %b %b expected=%h %h %h %h %b %b %b",
                         phase, $time, code_a, code_b, c12_a, c12_b, gain_x2, {pd_a, pd_b}, ref_on,
                         m_dac[0], m_dac[1], m_dac[0][15:4], m_dac[1][15:4], m_gain,
                         {m_pd[0], m_pd[1]}, exp_ref);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic shift_bits(logic [23:0] w, int nbits);
        fsel_n = 1'b0; step(1);
        for (int i = 23; i > 23 - nbits; i--) begin
            sdin = w[i]; sclk = 1'b1; step(2);
            sclk = 1'b0; step(2);
        end
        sclk = 1'b1; step(1);
        fsel_n = 1'b1; step(2);
    endtask

    task automatic send(logic [2:0] cmd, logic [2:0] adr, logic [15:0] d);
        shift_bits({2'b11, cmd, adr, d}, 24);
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        step(1);
        cmp_en = 1'b1;

        // R1 reset state
        check("R1 code_a", 32'(code_a), 0);
        check("R1 code_b", 32'(code_b), 0);
        check("R1 gain/pd/ref", {27'd0, gain_x2, pd_a ^ pd_b, ref_on}, 0);

        phase = "R3";
        send(3'd0, 3'd0, 16'h1234);
        check("R3 input write held back", 32'(code_a), 0);

        phase = "R4";
        send(3'd1, 3'd0, 16'h0000);
        check("R4 software update A", 32'(code_a), 32'h1234);
        send(3'd3, 3'd1, 16'hABCD);
        check("R4 write+update B", 32'(code_b), 32'hABCD);
        phase = "R6";
        check("R6 12-bit code B", 32'(c12_b), 32'hABC);

        phase = "R5";
        send(3'd0, 3'd7, 16'h5555);
        send(3'd0, 3'd3, 16'h9999);
        send(3'd1, 3'd7, 16'h0000);
        check("R5 broadcast A", 32'(code_a), 32'h5555);
        check("R5 broadcast B (unused address ignored)", 32'(code_b), 32'h5555);

        phase = "R2";
        shift_bits({2'b11, 3'd3, 3'd0, 16'hFFFF}, 20);
        check("R2 short frame dropped", 32'(code_a), 32'h5555);
        send(3'd1, 3'd0, 16'h0000);
        check("R2 short frame left input intact", 32'(code_a), 32'h5555);

        phase = "R4";
        send(3'd2, 3'd0, 16'h0102);
        check("R4 write A update all A", 32'(code_a), 32'h0102);
        check("R4 write A update all B", 32'(code_b), 32'h5555);

        phase = "R7";
        send(3'd6, 3'd0, 16'h0002);
        send(3'd0, 3'd1, 16'h7777);
        send(3'd0, 3'd0, 16'h3333);
        check("R7 pending B before pin", 32'(code_b), 32'h5555);
        upd_n = 1'b0; step(2);
        check("R7 pin edge updates masked B", 32'(code_b), 32'h7777);
        check("R7 pin edge skips unmasked A", 32'(code_a), 32'h0102);
        upd_n = 1'b1; step(2);

        phase = "R8";
        upd_n = 1'b0; step(2);
        send(3'd0, 3'd1, 16'h4444);
        check("R8 sync update B at frame end", 32'(code_b), 32'h4444);
        check("R8 unmasked A untouched", 32'(code_a), 32'h0102);
        upd_n = 1'b1; step(2);

        phase = "R11";
        send(3'd7, 3'd1, 16'h0002);
        check("R11 gain select", 32'(gain_x2), 32'h2);

        phase = "R10";
        check("R10 reference off by default", 32'(ref_on), 0);
        send(3'd7, 3'd0, 16'h0001);
        check("R10 reference enabled", 32'(ref_on), 1);

        phase = "R9";
        send(3'd4, 3'd0, 16'h0011);
        check("R9 A powered down", {30'd0, pd_a}, 32'h1);
        check("R9 ref kept with B normal", 32'(ref_on), 1);
        send(3'd4, 3'd0, 16'h0032);
        check("R9 B powered down", {30'd0, pd_b}, 32'h3);
        check("R10 ref forced off both down", 32'(ref_on), 0);
        send(3'd4, 3'd0, 16'h0001);
        check("R10 ref back on with A normal", 32'(ref_on), 1);

        phase = "R13";
        clr_n = 1'b0; step(3);
        check("R13 clear codes", {code_a, code_b}, 0);
        clr_n = 1'b1; step(2);
        send(3'd1, 3'd7, 16'h0000);
        check("R13 inputs also cleared", {code_a, code_b}, 0);

        phase = "R12";
        send(3'd3, 3'd0, 16'h1111);
        check("R12 setup code A", 32'(code_a), 32'h1111);
        send(3'd5, 3'd0, 16'h0000);
        check("R12 code reset clears code", 32'(code_a), 0);
        check("R12 code reset keeps gain", 32'(gain_x2), 32'h2);
        check("R12 code reset keeps ref", 32'(ref_on), 1);
        send(3'd5, 3'd0, 16'h0001);
        check("R12 full reset gain/pd/ref", {27'd0, gain_x2, pd_a | pd_b, ref_on}, 0);
        send(3'd0, 3'd1, 16'h2222);
        upd_n = 1'b0; step(2);
        check("R12 full reset cleared mask", 32'(code_b), 0);
        upd_n = 1'b1; step(2);

        step(4);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule